// File: doc/BRIEF.md
# SPI Master Byte Shifter

This block moves one byte at a time over a four-wire serial link as the master. A write on the transmit port loads a byte and starts a transfer. The block drops the active-low chip select, runs eight serial clock periods, shifts the byte out most significant bit first, and shifts eight bits in from the slave. At the end it raises chip select, places the received byte on the receive port and sets a buffer-full flag. Reading the receive byte clears that flag.

Three configuration inputs set the timing. One sets the idle level of the serial clock. One chooses whether outgoing data changes when the clock leaves its idle level or when it returns to it. One chooses whether incoming data is captured in the middle of each output bit or at its end. The sample point is chosen independently of the other two. An 8-bit divider value sets the serial clock rate. The configuration is latched when a transfer starts.

Top module: `spi_master_shifter`

## Requirements
- R1: While rst_ni is low, cs_no is 1, buf_full_o is 0, wcol_o is 0 and sclk_o equals cpol_i.
- R2: With en_i high and no transfer running, a tx_wr_i pulse starts a transfer. cs_no goes low on the next clock edge and stays low for exactly 16*(div_i+1) system clocks. Each serial bit lasts 2*(div_i+1) clocks, made of two halves of div_i+1 clocks each.
- R3: While cs_no is high, sclk_o sits at the level given by cpol_i. It moves only during a transfer or when cpol_i changes.
- R4: With chg_on_trail_i = 1, the first half of each bit has sclk_o idle, and mosi_o changes only as sclk_o returns from active to idle. With chg_on_trail_i = 0, the first half of each bit has sclk_o active, and mosi_o changes only as sclk_o leaves idle for active.
- R5: With smp_end_i = 0, each input bit is the miso_i level in the last clock of the bit's first half, which is mid-bit. With smp_end_i = 1, it is the miso_i level in the last clock of the bit's second half, one system clock before the next output change.
- R6: Bits go out on mosi_o and come in from miso_i most significant bit first. The first received bit lands in bit 7 of rx_data_o.
- R7: On the clock edge that ends a transfer, cs_no rises, buf_full_o becomes 1 and rx_data_o takes the received byte. buf_full_o rises at no other time.
- R8: A rx_rd_i pulse while no transfer is finishing clears buf_full_o on the next edge.
- R9: A tx_wr_i pulse during a transfer does not change the byte being sent, and sets wcol_o. wcol_o stays set until the next accepted write clears it.
- R10: While en_i is low, any transfer is aborted, cs_no is 1, buf_full_o and wcol_o are cleared, and tx_wr_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| cpol_i | input | 1 | Serial clock idle level |
| chg_on_trail_i | input | 1 | 1: data changes active-to-idle; 0: idle-to-active |
| smp_end_i | input | 1 | 1: sample at end of bit; 0: sample mid-bit |
| div_i | input | 8 | Half-period divider, half period = div_i+1 clocks |
| tx_wr_i | input | 1 | Transmit write strobe, starts a transfer |
| tx_data_i | input | 8 | Transmit byte |
| rx_rd_i | input | 1 | Receive read strobe, clears buffer-full |
| rx_data_o | output | 8 | Last received byte |
| buf_full_o | output | 1 | Received byte waiting |
| wcol_o | output | 1 | Write collided with a running transfer |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Active-low chip select |

## Verification
The checks on edge placement and idle clock compare against the live configuration inputs. They therefore assume that cpol_i, chg_on_trail_i, smp_end_i and div_i stay constant while cs_no is low. The bench changes these inputs only between transfers, while chip select is high. The read-clear check assumes rx_rd_i is not pulsed in the cycle a transfer completes, and the bench reads only after it has seen buf_full_o set. The bench's slave model drives a different miso level in each half of every bit, so mid-bit and end-of-bit capture give different bytes.

// File: rtl/spi_ms_pkg.sv
package spi_ms_pkg;
  typedef struct packed {
    logic cpol;
    logic chg_on_trail;
    logic smp_end;
  } spi_cfg_t;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [DIVW-1:0] div_i,
  output logic            tick_o
);
  logic [DIVW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_bit_seq.sv
module spi_bit_seq #(
  parameter int DW = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic half_o,
  output logic shift_o,
  output logic done_o
);
  localparam int BITW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BITW-1:0] LAST_IDX = BITW'(DW - 1);

  logic [BITW-1:0] idx_q;
  logic            last;

  assign last    = (idx_q == LAST_IDX);
  assign shift_o = busy_o && tick_i && half_o && !last;
  assign done_o  = busy_o && tick_i && half_o && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      half_o <= 1'b0;
      idx_q  <= '0;
    end else if (!en_i) begin
      busy_o <= 1'b0;
      half_o <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      half_o <= 1'b0;
      idx_q  <= '0;
    end else if (busy_o && tick_i) begin
      half_o <= ~half_o;
      if (half_o) begin
        if (last) busy_o <= 1'b0;
        else      idx_q  <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_shift_data.sv
module spi_shift_data #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] tx_i,
  input  logic          shift_i,
  input  logic          cap_i,
  input  logic          miso_i,
  output logic          mosi_o,
  output logic [DW-1:0] rx_sr_o,
  output logic [DW-1:0] rx_next_o
);
  logic [DW-1:0] tx_sr_q;

  assign mosi_o    = tx_sr_q[DW-1];
  assign rx_next_o = {rx_sr_o[DW-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_sr_q <= '0;
    else if (load_i)  tx_sr_q <= tx_i;
    else if (shift_i) tx_sr_q <= {tx_sr_q[DW-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rx_sr_o <= '0;
    else if (load_i)  rx_sr_o <= '0;
    else if (cap_i)   rx_sr_o <= rx_next_o;
  end
endmodule

// File: rtl/spi_master_shifter.sv
module spi_master_shifter
  import spi_ms_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            cpol_i,
  input  logic            chg_on_trail_i,
  input  logic            smp_end_i,
  input  logic [DIVW-1:0] div_i,
  input  logic            tx_wr_i,
  input  logic [DW-1:0]   tx_data_i,
  input  logic            rx_rd_i,
  output logic [DW-1:0]   rx_data_o,
  output logic            buf_full_o,
  output logic            wcol_o,
  output logic            sclk_o,
  output logic            mosi_o,
  input  logic            miso_i,
  output logic            cs_no
);
  spi_cfg_t      cfg_q;
  logic          busy, half, tick, shift, done, start, cap, mosi_sr;
  logic [DW-1:0] rx_sr, rx_next;

  assign start = en_i && tx_wr_i && !busy;
  // capture on the tick closing the first half (mid) or second half (end)
  assign cap   = busy && tick && (cfg_q.smp_end ? half : !half);

  spi_clk_div #(.DIVW(DIVW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (div_i),
    .tick_o (tick)
  );

  spi_bit_seq #(.DW(DW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .start_i (start),
    .tick_i  (tick),
    .busy_o  (busy),
    .half_o  (half),
    .shift_o (shift),
    .done_o  (done)
  );

  spi_shift_data #(.DW(DW)) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start),
    .tx_i      (tx_data_i),
    .shift_i   (shift),
    .cap_i     (cap),
    .miso_i    (miso_i),
    .mosi_o    (mosi_sr),
    .rx_sr_o   (rx_sr),
    .rx_next_o (rx_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= '0;
    else if (start) cfg_q <= '{cpol: cpol_i, chg_on_trail: chg_on_trail_i, smp_end: smp_end_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rx_data_o <= '0;
    else if (done) rx_data_o <= cfg_q.smp_end ? rx_next : rx_sr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      buf_full_o <= 1'b0;
    else if (!en_i)   buf_full_o <= 1'b0;
    else if (done)    buf_full_o <= 1'b1;
    else if (rx_rd_i) buf_full_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 wcol_o <= 1'b0;
    else if (!en_i)              wcol_o <= 1'b0;
    else if (tx_wr_i && busy)    wcol_o <= 1'b1;
    else if (start)              wcol_o <= 1'b0;
  end

  // first half idle when data changes on the trailing edge, active otherwise
  assign sclk_o = busy ? (cfg_q.cpol ^ (cfg_q.chg_on_trail ? half : !half)) : cpol_i;
  assign mosi_o = busy ? mosi_sr : 1'b0;
  assign cs_no  = !busy;
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk #(
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            cpol_i,
  input logic            chg_on_trail_i,
  input logic            smp_end_i,
  input logic [DIVW-1:0] div_i,
  input logic            tx_wr_i,
  input logic [DW-1:0]   tx_data_i,
  input logic            rx_rd_i,
  input logic [DW-1:0]   rx_data_o,
  input logic            buf_full_o,
  input logic            wcol_o,
  input logic            sclk_o,
  input logic            mosi_o,
  input logic            miso_i,
  input logic            cs_no
);
  p_sclk_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != $past(sclk_o)) |-> (!cs_no || !$past(cs_no) || cpol_i != $past(cpol_i)));

  p_mosi_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !$past(cs_no) && mosi_o != $past(mosi_o)) |->
    (chg_on_trail_i ? (sclk_o == cpol_i && $past(sclk_o) != cpol_i)
                    : (sclk_o != cpol_i && $past(sclk_o) == cpol_i)));

  p_full_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_full_o) |-> $rose(cs_no));

  p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && cs_no) |=> !buf_full_o);

  p_collision_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tx_wr_i && !cs_no) |=> wcol_o);

  p_disable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cs_no && !buf_full_o && !wcol_o));
endmodule

bind spi_master_shifter spi_master_chk #(.DW(DW), .DIVW(DIVW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .en_i           (en_i),
  .cpol_i         (cpol_i),
  .chg_on_trail_i (chg_on_trail_i),
  .smp_end_i      (smp_end_i),
  .div_i          (div_i),
  .tx_wr_i        (tx_wr_i),
  .tx_data_i      (tx_data_i),
  .rx_rd_i        (rx_rd_i),
  .rx_data_o      (rx_data_o),
  .buf_full_o     (buf_full_o),
  .wcol_o         (wcol_o),
  .sclk_o         (sclk_o),
  .mosi_o         (mosi_o),
  .miso_i         (miso_i),
  .cs_no          (cs_no)
);

// File: tb/tb_spi_master_shifter.sv
`timescale 1ns/1ps
module tb_spi_master_shifter;
  logic       clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic       cpol_i = 1'b0, chg_on_trail_i = 1'b0, smp_end_i = 1'b0;
  logic [7:0] div_i = 8'd0, tx_data_i = 8'd0;
  logic       tx_wr_i = 1'b0, rx_rd_i = 1'b0, miso_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       buf_full_o, wcol_o, sclk_o, mosi_o, cs_no;

  spi_master_shifter dut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0;

  typedef struct {
    logic [7:0] rx;
    logic [7:0] tx;
    int         len;
  } exp_t;
  exp_t sb_q[$];

  logic [7:0] a_pat = '0, b_pat = '0, tx_cap = '0;
  int   n_cyc = 0, sclk_bad = 0, d1, hh, hf, bi;
  logic bf_q = 1'b0, exp_s;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor + slave model
  always @(negedge clk_i) begin
    if (buf_full_o && !bf_q) begin
      if (sb_q.size() == 0) chk("R7", "unexpected completion", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R5", "rx byte", 32'(rx_data_o), 32'(e.rx));
        chk("R6", "mosi byte", 32'(tx_cap), 32'(e.tx));
        chk("R2", "cs low cycles", 32'(n_cyc), 32'(e.len));
        chk("R4", "sclk waveform errors", 32'(sclk_bad), 32'd0);
      end
    end
    bf_q = buf_full_o;
    if (!cs_no) begin
      d1 = int'(div_i) + 1;
      hh = n_cyc / d1;
      hf = hh % 2;
      bi = hh / 2;
      if (n_cyc == 0) begin
        tx_cap   = '0;
        sclk_bad = 0;
      end
      if (bi < 8) begin
        miso_i = (hf == 1) ? b_pat[7-bi] : a_pat[7-bi];
        exp_s  = cpol_i ^ (chg_on_trail_i ? (hf == 1) : (hf == 0));
        if (sclk_o !== exp_s) sclk_bad++;
        if (hf == 1 && (n_cyc % d1) == 0) tx_cap[7-bi] = mosi_o;
      end
      n_cyc++;
    end else begin
      n_cyc  = 0;
      miso_i = 1'b0;
    end
  end

  task automatic xfer(input logic cp, input logic ce, input logic sm, input logic [7:0] dv,
                      input logic [7:0] tx, input logic [7:0] a, input logic coll, input logic rd);
    exp_t e;
    @(negedge clk_i);
    cpol_i = cp; chg_on_trail_i = ce; smp_end_i = sm; div_i = dv;
    a_pat = a; b_pat = ~a;
    e.rx = sm ? ~a : a; e.tx = tx; e.len = 16 * (int'(dv) + 1);
    sb_q.push_back(e);
    tx_wr_i = 1'b1; tx_data_i = tx;
    @(negedge clk_i);
    tx_wr_i = 1'b0;
    chk("R2", "cs low after write", 32'(cs_no), 32'd0);
    chk("R9", "wcol cleared by accepted write", 32'(wcol_o), 32'd0);
    if (coll) begin
      repeat (5) @(negedge clk_i);
      tx_wr_i = 1'b1; tx_data_i = ~tx;
      @(negedge clk_i);
      tx_wr_i = 1'b0;
      chk("R9", "wcol after busy write", 32'(wcol_o), 32'd1);
    end
    for (int g = 0; g < 5000 && !buf_full_o; g++) @(negedge clk_i);
    chk("R7", "buf_full set", 32'(buf_full_o), 32'd1);
    chk("R3", "sclk idle after transfer", 32'(sclk_o), 32'(cp));
    if (rd) begin
      rx_rd_i = 1'b1;
      @(negedge clk_i);
      rx_rd_i = 1'b0;
      chk("R8", "buf_full cleared by read", 32'(buf_full_o), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "cs in reset", 32'(cs_no), 32'd1);
    chk("R1", "buf_full in reset", 32'(buf_full_o), 32'd0);
    chk("R1", "wcol in reset", 32'(wcol_o), 32'd0);
    chk("R1", "sclk in reset", 32'(sclk_o), 32'd0);
    rst_ni = 1'b1; en_i = 1'b1;
    @(negedge clk_i);
    cpol_i = 1'b1;
    @(negedge clk_i);
    chk("R3", "idle sclk follows polarity", 32'(sclk_o), 32'd1);

    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 2; k++) begin
        xfer(c[2], c[1], c[0], (k == 0) ? 8'd0 : 8'd2,
             8'hA5 ^ 8'(c * 37 + k * 11), 8'h3C ^ 8'(c * 19 + k), 1'b0, 1'b1);
      end
    end

    // R9: collision leaves the byte intact, next accepted write clears wcol
    xfer(1'b0, 1'b1, 1'b0, 8'd1, 8'h96, 8'hE1, 1'b1, 1'b1);
    chk("R9", "wcol held until next write", 32'(wcol_o), 32'd1);
    xfer(1'b0, 1'b0, 1'b1, 8'd1, 8'h5A, 8'h0F, 1'b0, 1'b1);

    // R10: disable clears a pending full flag
    xfer(1'b1, 1'b1, 1'b1, 8'd0, 8'hC3, 8'h81, 1'b0, 1'b0);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R10", "buf_full cleared by disable", 32'(buf_full_o), 32'd0);
    en_i = 1'b1;

    // R10: abort mid transfer
    @(negedge clk_i);
    div_i = 8'd3; tx_wr_i = 1'b1; tx_data_i = 8'h77;
    @(negedge clk_i);
    tx_wr_i = 1'b0;
    repeat (10) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R10", "cs after abort", 32'(cs_no), 32'd1);
    chk("R10", "buf_full after abort", 32'(buf_full_o), 32'd0);

    // R10: write ignored while disabled
    tx_wr_i = 1'b1; tx_data_i = 8'h11;
    @(negedge clk_i);
    tx_wr_i = 1'b0;
    @(negedge clk_i);
    chk("R10", "cs stays high on disabled write", 32'(cs_no), 32'd1);
    chk("R10", "no completion when disabled", 32'(buf_full_o), 32'd0);
    en_i = 1'b1;

    xfer(1'b0, 1'b1, 1'b0, 8'd5, 8'h2D, 8'hB4, 1'b0, 1'b1);
    repeat (4) @(negedge clk_i);
    chk("R7", "scoreboard drained", 32'(sb_q.size()), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule